// File: doc/BRIEF.md
# Multi-Queue Shared-Buffer FIFO Engine

This block keeps a set of independent hardware FIFOs in one on-chip word buffer. Each queue has a base location, a power-of-two depth, an entry length of one, two or four words, and two watermark thresholds. All of these, together with the queue's live read and write pointers, sit in a single 32-bit configuration word per queue. A 32-bit memory-mapped slave port gives each queue a four-word access window. A write to the window pushes a word at the tail of that queue. A read from the window pops a word from its head. Multi-word entries are moved one word per access, and the queue's pointer only moves once the whole entry has gone through.

Every queue drives empty, nearly-empty, nearly-full and full levels to a separate status block. It also drives one-cycle underflow and overflow events. Each window is 16 bytes, and the window of queue q starts at byte q×16. Configuration word q sits at byte `CFG_OFF` + 4×q. Read data is registered and is valid on the cycle after the read access. The port takes one access per cycle.

Top module: `mqf_engine`

## Requirements
- R1: After reset every queue is empty with nearly-empty set and nearly-full and full clear, and every configuration word reads 0.
- R2: Configuration word layout, LSB first: [1:0] depth code (depth = 4<<code words), [3:2] entry code (0:1, 1:2, 2 or 3:4 words), [11:4] base word address, [15:12] nearly-empty threshold, [19:16] nearly-full threshold, [25:20] read pointer, [31:26] write pointer. Pointers count words modulo twice the depth. A write replaces the word and clears both in-entry offsets. A read returns the word with the live pointers.
- R3: Words leave a queue in the order they entered. Popped data is on `rdata_o` in the cycle after the read access.
- R4: A pointer advances by the entry length only after the last word of an entry. Until then the flags and the pointer stay as they were.
- R5: The buffer index is (pointer + offset) masked with depth−1, added to the base. Queues whose pointers wrap keep their order.
- R6: full is set when the word count equals the depth. A push to a full queue stores nothing, leaves the pointers unchanged, and pulses overflow for that queue in the next cycle.
- R7: A pop from an empty queue leaves the pointers unchanged, returns 0, and pulses underflow for that queue in the next cycle.
- R8: nearly-empty is set when the number of stored entries is at or below the nearly-empty threshold.
- R9: nearly-full is set when the number of free entries is at or below the nearly-full threshold.
- R10: Queues are independent. Each keeps its own in-entry offsets, so partial entries on different queues may be interleaved.
- R11: The word position inside an entry comes from the queue's offset counter and not from address bits [3:2]. Accesses outside the windows and the configuration words, or not word-aligned, change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write (push or config), 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| empty_o | output | NUM_Q | Queue holds no entry |
| nempty_o | output | NUM_Q | Entries at or below nearly-empty threshold |
| nfull_o | output | NUM_Q | Free entries at or below nearly-full threshold |
| full_o | output | NUM_Q | Queue holds depth words |
| underflow_o | output | NUM_Q | One-cycle pulse: pop from empty queue |
| overflow_o | output | NUM_Q | One-cycle pulse: push to full queue |

## Verification
The assertions assume that software only writes consistent configuration words. Read and write pointers must be multiples of the entry length, and their distance must not exceed the depth. A queue's configuration must not be rewritten while one of its entries is half-transferred. The stimulus builds every configuration word with pointers equal to each other and aligned to the entry length. It completes every entry it starts before it reconfigures that queue, so the word-count bound and the stable-pointer properties hold throughout.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
  localparam int PTR_W  = 6;
  localparam int THR_W  = 4;
  localparam int BASE_W = 8;
  localparam int CODE_W = 2;
  localparam int OFF_W  = 2;

  typedef struct packed {
    logic [PTR_W-1:0]  wp;
    logic [PTR_W-1:0]  rp;
    logic [THR_W-1:0]  nf_thr;
    logic [THR_W-1:0]  ne_thr;
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] esz_code;
    logic [CODE_W-1:0] qsz_code;
  } qcfg_t;

  function automatic logic [PTR_W:0] qsz_words(input logic [CODE_W-1:0] c);
    return (PTR_W+1)'(4) << c;
  endfunction

  function automatic logic [1:0] esz_log(input logic [CODE_W-1:0] c);
    return (c == 2'd0) ? 2'd0 : (c == 2'd1) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/mqf_decode.sv
module mqf_decode #(
  parameter int                NUM_Q   = 8,
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] CFG_OFF = 12'h400,
  localparam int               QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_Q-1:0]  push_o,
  output logic [NUM_Q-1:0]  pop_o,
  output logic [NUM_Q-1:0]  cfg_we_o,
  output logic [QW-1:0]     sel_o,
  output logic              win_rd_o,
  output logic              cfg_rd_o
);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(NUM_Q * 16);
  localparam logic [ADDR_W-1:0] CFG_END = CFG_OFF + ADDR_W'(NUM_Q * 4);

  logic              aligned, win_hit, cfg_hit;
  logic [ADDR_W-1:0] coff;
  logic              unused_word_bits;

  assign unused_word_bits = ^addr_i[3:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign coff    = addr_i - CFG_OFF;
  assign win_hit = aligned && (addr_i < WIN_END);
  assign cfg_hit = aligned && (addr_i >= CFG_OFF) && (addr_i < CFG_END);
  assign sel_o   = win_hit ? addr_i[4 +: QW] : coff[2 +: QW];
  assign win_rd_o = req_i && !we_i && win_hit;
  assign cfg_rd_o = req_i && !we_i && cfg_hit;

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      push_o[q]   = req_i &&  we_i && win_hit && (sel_o == QW'(q));
      pop_o[q]    = req_i && !we_i && win_hit && (sel_o == QW'(q));
      cfg_we_o[q] = req_i &&  we_i && cfg_hit && (sel_o == QW'(q));
    end
  end
endmodule

// File: rtl/mqf_buffer.sv
module mqf_buffer #(
  parameter int DATA_W = 32,
  parameter int AW     = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/mqf_queue_ctl.sv
module mqf_queue_ctl
  import mqf_pkg::*;
#(
  parameter int BUF_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [31:0]       cfg_o,
  output logic [BUF_AW-1:0] tail_addr_o,
  output logic [BUF_AW-1:0] head_addr_o,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic              empty_o,
  output logic              nempty_o,
  output logic              nfull_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              udf_o
);
  qcfg_t            cfg_q;
  logic [OFF_W-1:0] woff_q, roff_q;
  logic             ovf_q, udf_q;

  logic [PTR_W:0]   size, free;
  logic [PTR_W+1:0] dbl;
  logic [PTR_W-1:0] pmask, imask, cnt, entries, widx, ridx, wp_next, rp_next;
  logic [PTR_W:0]   free_e;
  logic [1:0]       el;
  logic [OFF_W:0]   esz;
  logic             w_last, r_last;

  always_comb begin
    size    = qsz_words(cfg_q.qsz_code);
    dbl     = {1'b0, size} << 1;
    pmask   = PTR_W'(dbl - 1'b1);
    imask   = PTR_W'(size - 1'b1);
    el      = esz_log(cfg_q.esz_code);
    esz     = (OFF_W+1)'(1) << el;
    cnt     = (cfg_q.wp - cfg_q.rp) & pmask;
    free    = size - {1'b0, cnt};
    entries = cnt >> el;
    free_e  = free >> el;
    w_last  = ({1'b0, woff_q} == esz - 1'b1);
    r_last  = ({1'b0, roff_q} == esz - 1'b1);
    widx    = (cfg_q.wp + PTR_W'(woff_q)) & imask;
    ridx    = (cfg_q.rp + PTR_W'(roff_q)) & imask;
    wp_next = (cfg_q.wp + PTR_W'(esz)) & pmask;
    rp_next = (cfg_q.rp + PTR_W'(esz)) & pmask;
  end

  assign full_o      = ({1'b0, cnt} == size);
  assign empty_o     = (cnt == '0);
  assign nempty_o    = (entries <= PTR_W'(cfg_q.ne_thr));
  assign nfull_o     = (free_e <= (PTR_W+1)'(cfg_q.nf_thr));
  assign push_ok_o   = push_i && !full_o;
  assign pop_ok_o    = pop_i && !empty_o;
  assign tail_addr_o = BUF_AW'(cfg_q.base + BASE_W'(widx));
  assign head_addr_o = BUF_AW'(cfg_q.base + BASE_W'(ridx));
  assign cfg_o       = cfg_q;
  assign ovf_o       = ovf_q;
  assign udf_o       = udf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      woff_q <= '0;
      roff_q <= '0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      ovf_q <= push_i && full_o;
      udf_q <= pop_i && empty_o;
      if (cfg_we_i) begin
        cfg_q  <= qcfg_t'(cfg_wdata_i);
        woff_q <= '0;
        roff_q <= '0;
      end else if (push_ok_o) begin
        if (w_last) begin
          cfg_q.wp <= wp_next;
          woff_q   <= '0;
        end else begin
          woff_q <= woff_q + 1'b1;
        end
      end else if (pop_ok_o) begin
        if (r_last) begin
          cfg_q.rp <= rp_next;
          roff_q   <= '0;
        end else begin
          roff_q <= roff_q + 1'b1;
        end
      end
    end
  end

  assert_ovf_holds_wp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !cfg_we_i) |=> ($stable(cfg_q.wp) && ovf_o));
  assert_udf_holds_rp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !cfg_we_i) |=> ($stable(cfg_q.rp) && udf_o));
  assert_partial_no_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !cfg_we_i && {1'b0, woff_q} != esz - 1'b1) |=> $stable(cfg_q.wp));
  assert_count_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt} <= size));
  assert_flag_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: rtl/mqf_engine.sv
module mqf_engine #(
  parameter int                NUM_Q   = 8,
  parameter int                ADDR_W  = 12,
  parameter int                BUF_AW  = 8,
  parameter logic [ADDR_W-1:0] CFG_OFF = 12'h400,
  localparam int               QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_Q-1:0]  empty_o,
  output logic [NUM_Q-1:0]  nempty_o,
  output logic [NUM_Q-1:0]  nfull_o,
  output logic [NUM_Q-1:0]  full_o,
  output logic [NUM_Q-1:0]  underflow_o,
  output logic [NUM_Q-1:0]  overflow_o
);
  logic [NUM_Q-1:0]  push_v, pop_v, cfg_we_v, push_ok_v, pop_ok_v;
  logic [QW-1:0]     sel;
  logic              win_rd, cfg_rd;
  logic [31:0]       cfg_all [NUM_Q];
  logic [BUF_AW-1:0] tail_all [NUM_Q];
  logic [BUF_AW-1:0] head_all [NUM_Q];
  logic [31:0]       mem_rd, rdata_q;

  mqf_decode #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .CFG_OFF(CFG_OFF)) u_dec (
    .req_i, .we_i, .addr_i,
    .push_o(push_v), .pop_o(pop_v), .cfg_we_o(cfg_we_v),
    .sel_o(sel), .win_rd_o(win_rd), .cfg_rd_o(cfg_rd)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    mqf_queue_ctl #(.BUF_AW(BUF_AW)) u_q (
      .clk_i, .rst_ni,
      .cfg_we_i(cfg_we_v[g]), .cfg_wdata_i(wdata_i),
      .push_i(push_v[g]), .pop_i(pop_v[g]),
      .cfg_o(cfg_all[g]), .tail_addr_o(tail_all[g]), .head_addr_o(head_all[g]),
      .push_ok_o(push_ok_v[g]), .pop_ok_o(pop_ok_v[g]),
      .empty_o(empty_o[g]), .nempty_o(nempty_o[g]), .nfull_o(nfull_o[g]),
      .full_o(full_o[g]), .ovf_o(overflow_o[g]), .udf_o(underflow_o[g])
    );
  end

  mqf_buffer #(.DATA_W(32), .AW(BUF_AW)) u_buf (
    .clk_i,
    .we_i(|push_ok_v), .waddr_i(tail_all[sel]), .wdata_i(wdata_i),
    .raddr_i(head_all[sel]), .rdata_o(mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) begin
      if (win_rd)      rdata_q <= (|pop_ok_v) ? mem_rd : 32'h0;
      else if (cfg_rd) rdata_q <= cfg_all[sel];
      else             rdata_q <= 32'h0;
    end
  end
  assign rdata_o = rdata_q;

  assert_single_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_v, pop_v, cfg_we_v}));
  assert_unmapped_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(|{push_v, pop_v, cfg_we_v}) && !cfg_rd)
      |=> ($stable(empty_o) && $stable(full_o) && rdata_o == 32'h0 || $past(we_i)));
  assert_pop_data_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && !(|pop_ok_v)) |=> (rdata_o == 32'h0));
endmodule

// File: tb/tb_mqf_engine.sv
module tb_mqf_engine;
  localparam int NQ = 8;
  localparam logic [11:0] COFF = 12'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NQ-1:0] empty, nempty, nfull, full, udf, ovf;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mqf_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .empty_o(empty), .nempty_o(nempty),
    .nfull_o(nfull), .full_o(full), .underflow_o(udf), .overflow_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  function automatic logic [31:0] mk(int wp, int rp, int nf, int ne, int base, int esc, int szc);
    return {6'(wp), 6'(rp), 4'(nf), 4'(ne), 8'(base), 2'(esc), 2'(szc)};
  endfunction

  function automatic logic [31:0] pat(int q, int rnd, int e, int w);
    return {8'hA5, 4'(q), 4'(rnd), 8'(e), 8'(w)};
  endfunction

  task automatic flags(input string tag, input int q, input int n, input int cap,
                       input int ne_t, input int nf_t);
    chk({tag, " R6 full"},   32'(full[q]),   32'(n == cap));
    chk({tag, " R3 empty"},  32'(empty[q]),  32'(n == 0));
    chk({tag, " R8 nempty"}, 32'(nempty[q]), 32'(n <= ne_t));
    chk({tag, " R9 nfull"},  32'(nfull[q]),  32'((cap - n) <= nf_t));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int q = 0; q < NQ; q++) begin
      chk("R1 empty", 32'(empty[q]), 32'd1);
      chk("R1 nempty", 32'(nempty[q]), 32'd1);
      chk("R1 nfull", 32'(nfull[q]), 32'd0);
      chk("R1 full", 32'(full[q]), 32'd0);
      bus(1'b0, COFF + 12'(4 * q), '0);
      chk("R1 cfg", rdata, 32'h0);
    end

    // sweep depth x entry size x start pointer
    for (int szc = 0; szc < 3; szc++)
      for (int esc = 0; esc < 3; esc++)
        for (int rnd = 0; rnd < 2; rnd++) begin
          int q, size, esz, cap, ne_t, nf_t, p0, base, pm, wpe;
          logic [11:0] win;
          q = (szc * 3 + esc) % NQ;
          size = 4 << szc; esz = 1 << esc; cap = size / esz;
          ne_t = (szc + esc) % 3; nf_t = (esc + rnd) % 3;
          p0 = rnd ? size - esz : 0;
          base = q * 32; pm = 2 * size - 1;
          win = 12'(q * 16);
          bus(1'b1, COFF + 12'(4 * q), mk(p0, p0, nf_t, ne_t, base, esc, szc));
          bus(1'b0, COFF + 12'(4 * q), '0);
          chk("R2 cfg readback", rdata, mk(p0, p0, nf_t, ne_t, base, esc, szc));
          flags("init", q, 0, cap, ne_t, nf_t);
          for (int e = 0; e < cap; e++)
            for (int w = 0; w < esz; w++) begin
              bus(1'b1, win + 12'(4 * w), pat(q, rnd, e, w));
              if (w < esz - 1) chk("R4 partial push", 32'(empty[q]), 32'(e == 0));
              else flags("push", q, e + 1, cap, ne_t, nf_t);
            end
          wpe = (p0 + size) & pm;
          bus(1'b1, win, 32'hDEAD_BEEF);
          chk("R6 overflow pulse", 32'(ovf[q]), 32'd1);
          bus(1'b0, COFF + 12'(4 * q), '0);
          chk("R6 pointers kept", rdata, mk(wpe, p0, nf_t, ne_t, base, esc, szc));
          chk("R6 pulse one cycle", 32'(ovf[q]), 32'd0);
          for (int e = 0; e < cap; e++)
            for (int w = 0; w < esz; w++) begin
              bus(1'b0, win + 12'(4 * w), '0);
              chk(rnd ? "R5 wrapped order" : "R3 order", rdata, pat(q, rnd, e, w));
              if (w < esz - 1) chk("R4 partial pop", 32'(full[q]), 32'(e == 0));
              else flags("pop", q, cap - e - 1, cap, ne_t, nf_t);
            end
          bus(1'b0, win, '0);
          chk("R7 underflow pulse", 32'(udf[q]), 32'd1);
          chk("R7 data zero", rdata, 32'h0);
          bus(1'b0, COFF + 12'(4 * q), '0);
          chk("R7 pointers kept", rdata, mk(wpe, wpe, nf_t, ne_t, base, esc, szc));
        end

    // R10 interleaved partial entries on two queues
    bus(1'b1, COFF + 12'(4 * 6), mk(0, 0, 0, 0, 192, 1, 1));
    bus(1'b1, COFF + 12'(4 * 7), mk(0, 0, 0, 0, 224, 0, 0));
    bus(1'b1, 12'(6 * 16), 32'h6000_0001);
    bus(1'b1, 12'(7 * 16), 32'h7000_0001);
    chk("R10 q6 still empty", 32'(empty[6]), 32'd1);
    chk("R10 q7 holds entry", 32'(empty[7]), 32'd0);
    bus(1'b1, 12'(6 * 16 + 4), 32'h6000_0002);
    chk("R10 q6 committed", 32'(empty[6]), 32'd0);
    bus(1'b0, 12'(7 * 16), '0);
    chk("R10 q7 data", rdata, 32'h7000_0001);
    bus(1'b0, 12'(6 * 16), '0);
    chk("R10 q6 word0", rdata, 32'h6000_0001);
    bus(1'b0, 12'(6 * 16 + 4), '0);
    chk("R10 q6 word1", rdata, 32'h6000_0002);

    // R11 word position from offset counter, not address
    bus(1'b1, 12'(6 * 16 + 12), 32'hC0C0_0000);
    bus(1'b1, 12'(6 * 16 + 8), 32'hC0C0_0001);
    bus(1'b0, 12'(6 * 16), '0);
    chk("R11 offset word0", rdata, 32'hC0C0_0000);
    bus(1'b0, 12'(6 * 16), '0);
    chk("R11 offset word1", rdata, 32'hC0C0_0001);
    chk("R11 q6 empty", 32'(empty[6]), 32'd1);

    // R11 unmapped and misaligned accesses
    bus(1'b1, 12'h200, 32'h1234_5678);
    bus(1'b1, 12'(6 * 16 + 1), 32'h1234_5678);
    chk("R11 unmapped write q6", 32'(empty[6]), 32'd1);
    bus(1'b0, 12'h200, '0);
    chk("R11 unmapped read", rdata, 32'h0);
    bus(1'b0, COFF + 12'(4 * 6), '0);
    chk("R11 cfg untouched", rdata, mk(4, 4, 0, 0, 192, 1, 1));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule